// File: doc/BRIEF.md
# Paged Address Translation Map

This block sits between a network controller, the host and a local board RAM. It turns a 24-bit byte address into a physical RAM address. A host-writable map of page descriptors does the translation. The four most significant address bits play no part. The next ten bits pick one of 1024 descriptors, and the low ten bits are the byte offset inside a 1024-byte page. Each descriptor holds a 12-bit physical page frame, a routing bit and a byte-order bit. The routing bit sends the access either to on-board memory or to memory on an auxiliary bus.

The same translation serves controller traffic and host traffic into board RAM. Whichever side wins the external arbitration presents its request on the single translation port. The block registers the result and presents it one cycle later. It also steers the data: a 16-bit transfer is byte-swapped when the page is in big-endian order, and an 8-bit transfer lands on one byte lane with a matching strobe. Read data returned by the RAM goes back through the same steering.

The descriptor that covers the top of the address space is an ordinary entry. Software points it at a low physical page so that a fixed configuration pointer near address 0xFFFFF4 resolves into real RAM.

Top module: `pagemap_xlate`

## Requirements
- R1: After reset every descriptor reads back as 0x0000, and `xl_vld` and `xl_err` are low.
- R2: The descriptor index is address bits 19:10 and the page offset is bits 9:0. Bits 23:20 have no effect on any output.
- R3: For a legal request in cycle N, `xl_vld` is high in cycle N+1. In that cycle `xl_paddr` = {descriptor bits 11:0, offset} with bit 0 adjusted as R7 says, and `xl_mem_we` follows `xl_we`.
- R4: `xl_aux` equals descriptor bit 13: 1 sends the access to the auxiliary bus, 0 to on-board memory.
- R5: `xl_swap` equals descriptor bit 15. For a 16-bit access with bit 15 set, write data reaches `xl_mem_wdata` with its two bytes exchanged, and read data from `mem_rdata` reaches `xl_rdata` exchanged as well. With bit 15 clear, both pass through unchanged.
- R6: An 8-bit access (`xl_size` = 2'b00) uses byte lane L = address bit 0 XOR descriptor bit 15, where lane 0 is bits 7:0 and lane 1 is bits 15:8. `xl_mem_be` has only bit L set. The write byte (`xl_wdata[7:0]`) is placed on lane L. `xl_rdata` returns lane L of `mem_rdata` zero-extended.
- R7: A 16-bit access (`xl_size` = 2'b01) drives `xl_mem_be` = 2'b11 and forces `xl_paddr` bit 0 to 0.
- R8: A request with `xl_size` 2'b10 or 2'b11 is rejected. In the next cycle `xl_err` is high, `xl_vld` is low, and `xl_mem_be` and `xl_mem_we` are 0.
- R9: A request in the cycle after a descriptor write sees the new value. A request in the same cycle as the write sees the old value.
- R10: `map_rdata` returns the full 16-bit stored descriptor in the cycle after `map_rd_en`.
- R11: Descriptor 1023 translates the top of the address space. Address 0xFFFFF4 with descriptor 1023 set to page frame 0 yields physical address 0x3F4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_wr_en | input | 1 | Host descriptor write strobe |
| map_rd_en | input | 1 | Host descriptor read strobe |
| map_idx | input | 10 | Descriptor index for host access |
| map_wdata | input | 16 | Descriptor write value |
| map_rdata | output | 16 | Descriptor read value, one cycle after strobe |
| xl_req | input | 1 | Translation request |
| xl_addr | input | 24 | Byte address to translate |
| xl_size | input | 2 | 00 byte, 01 halfword, 10/11 illegal |
| xl_we | input | 1 | Request is a write |
| xl_wdata | input | 16 | Write data from requester |
| xl_vld | output | 1 | Translated access valid |
| xl_err | output | 1 | Request rejected for illegal size |
| xl_paddr | output | 22 | Physical byte address (frame, offset) |
| xl_aux | output | 1 | Route to auxiliary bus memory |
| xl_swap | output | 1 | Page uses big-endian byte order |
| xl_mem_we | output | 1 | Write strobe to RAM |
| xl_mem_be | output | 2 | Byte-lane enables to RAM |
| xl_mem_wdata | output | 16 | Lane-steered write data to RAM |
| mem_rdata | input | 16 | Raw read data from RAM |
| xl_rdata | output | 16 | Lane-steered read data to requester |

## Verification
Assertions check on every cycle that a result is never both valid and rejected and that a valid access has at least one lane enabled. They also check that a byte access enables exactly one lane, that a halfword access is even-aligned, and that legal and illegal requests produce `xl_vld` or `xl_err` in the following cycle. The bench's scenarios are the only way to show which descriptor was used and what the translated frame and offset are. The same holds for whether the swap and routing bits follow the stored entry, the exact byte placement in both directions, the reset contents of the map, and the ordering of a descriptor write against a translation in the same or the next cycle.

// File: rtl/pxm_pkg.sv
// Package: shared encodings for the paged address translation map.
// Assumes 16-bit descriptors with fixed attribute bit positions.
package pxm_pkg;
    localparam int unsigned ENTRY_W  = 16;
    localparam int unsigned SWAP_BIT = 15;
    localparam int unsigned AUX_BIT  = 13;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_RSV2 = 2'b10,
        SZ_RSV3 = 2'b11
    } xl_size_e;

    // Exchange the two bytes of a halfword.
    function automatic logic [15:0] swap16(input logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction
endpackage

// File: rtl/pxm_map_store.sv
// Module: descriptor storage. Holds ENTRIES descriptors, cleared by reset.
// Host reads and writes go through one index. A registered read returns
// the value stored before a same-cycle write. The lookup side reads
// combinationally, so a write becomes visible on the next cycle.
module pxm_map_store #(
    parameter int unsigned IDX_W = 10,
    parameter int unsigned PFN_W = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         rd_en,
    input  logic [IDX_W-1:0]             idx,
    input  logic [pxm_pkg::ENTRY_W-1:0]  wdata,
    output logic [pxm_pkg::ENTRY_W-1:0]  rdata,
    input  logic [IDX_W-1:0]             lk_idx,
    output logic [PFN_W-1:0]             lk_pfn,
    output logic                         lk_swap,
    output logic                         lk_aux
);
    localparam int unsigned ENTRIES = 1 << IDX_W;

    logic [pxm_pkg::ENTRY_W-1:0] mem [ENTRIES];

    // Purpose: clear all descriptors on reset, store host writes otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[idx] <= wdata;
        end
    end

    // Purpose: registered host read-back of one descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= mem[idx];
        end
    end

    // Purpose: combinational field extraction for the translation path.
    always_comb begin
        lk_pfn  = mem[lk_idx][PFN_W-1:0];
        lk_swap = mem[lk_idx][pxm_pkg::SWAP_BIT];
        lk_aux  = mem[lk_idx][pxm_pkg::AUX_BIT];
    end
endmodule

// File: rtl/pxm_xlate_stage.sv
// Module: translation register stage. Legalises the access size, builds
// the physical address from the looked-up frame and the page offset, and
// steers write data and byte enables. All results are registered, so they
// appear one cycle after the request. Assumes lookup fields arrive in the
// request cycle.
module pxm_xlate_stage #(
    parameter int unsigned OFF_W = 10,
    parameter int unsigned PFN_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req,
    input  logic [OFF_W-1:0]        off,
    input  pxm_pkg::xl_size_e       size,
    input  logic                    we,
    input  logic [15:0]             wdata,
    input  logic [PFN_W-1:0]        pfn,
    input  logic                    swap,
    input  logic                    aux,
    output logic                    vld,
    output logic                    err,
    output logic [PFN_W+OFF_W-1:0]  paddr,
    output logic                    aux_q,
    output logic                    swap_q,
    output logic                    half_q,
    output logic                    lane_q,
    output logic                    mem_we,
    output logic [1:0]              mem_be,
    output logic [15:0]             mem_wdata
);
    import pxm_pkg::*;

    logic             legal;
    logic             half;
    logic             lane;
    logic [OFF_W-1:0] off_eff;
    logic [1:0]       be_n;
    logic [15:0]      wd_n;

    // Purpose: decode size, pick the byte lane and steer write data.
    always_comb begin
        legal = req && (size == SZ_BYTE || size == SZ_HALF);
        half  = (size == SZ_HALF);
        lane  = off[0] ^ swap;
        if (half) begin
            off_eff = {off[OFF_W-1:1], 1'b0};
            be_n    = 2'b11;
            wd_n    = swap ? swap16(wdata) : wdata;
        end else begin
            off_eff = off;
            be_n    = lane ? 2'b10 : 2'b01;
            wd_n    = {wdata[7:0], wdata[7:0]};
        end
    end

    // Purpose: register the translated access, or flag a rejected one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld       <= 1'b0;
            err       <= 1'b0;
            paddr     <= '0;
            aux_q     <= 1'b0;
            swap_q    <= 1'b0;
            half_q    <= 1'b0;
            lane_q    <= 1'b0;
            mem_we    <= 1'b0;
            mem_be    <= 2'b00;
            mem_wdata <= '0;
        end else begin
            vld <= legal;
            err <= req && !legal;
            if (legal) begin
                paddr     <= {pfn, off_eff};
                aux_q     <= aux;
                swap_q    <= swap;
                half_q    <= half;
                lane_q    <= lane;
                mem_we    <= we;
                mem_be    <= be_n;
                mem_wdata <= wd_n;
            end else begin
                mem_we <= 1'b0;
                mem_be <= 2'b00;
            end
        end
    end

    AST_VLD_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(vld && err)); // R8
    AST_LEGAL_GIVES_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !size[1]) |=> vld); // R3
    AST_ILLEGAL_GIVES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req && size[1]) |=> (err && !vld && mem_be == 2'b00)); // R8
    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !half_q) |-> $countones(mem_be) == 1); // R6
    AST_HALF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && half_q) |-> (mem_be == 2'b11 && paddr[0] == 1'b0)); // R7
    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |-> (mem_be == 2'b00 && !mem_we)); // R8
endmodule

// File: rtl/pxm_rd_return.sv
// Module: read-data steering. Uses the registered attributes of the
// access in flight and the raw RAM word of the same cycle. It swaps a
// halfword for big-endian pages, and picks and zero-extends one lane
// for byte reads. Outputs zero when no access is valid.
module pxm_rd_return (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vld,
    input  logic        half,
    input  logic        swap,
    input  logic        lane,
    input  logic [15:0] raw,
    output logic [15:0] rdata
);
    import pxm_pkg::*;

    // Purpose: steer returned RAM data toward the requester.
    always_comb begin
        if (!vld) begin
            rdata = '0;
        end else if (half) begin
            rdata = swap ? swap16(raw) : raw;
        end else begin
            rdata = {8'h00, (lane ? raw[15:8] : raw[7:0])};
        end
    end

    AST_BYTE_RD_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !half) |-> rdata[15:8] == 8'h00); // R6
endmodule

// File: rtl/pagemap_xlate.sv
// Module: top of the paged address translation map. The top address bits
// are dropped, the middle bits index the descriptor store, and the low
// bits ride through as page offset into the registered translation stage.
// The read path steers returned RAM data with the stage's attributes.
// Assumes external arbitration puts one requester at a time on the port.
module pagemap_xlate #(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned OFF_W  = 10,
    parameter int unsigned PFN_W  = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   map_wr_en,
    input  logic                   map_rd_en,
    input  logic [IDX_W-1:0]       map_idx,
    input  logic [15:0]            map_wdata,
    output logic [15:0]            map_rdata,
    input  logic                   xl_req,
    input  logic [ADDR_W-1:0]      xl_addr,
    input  logic [1:0]             xl_size,
    input  logic                   xl_we,
    input  logic [15:0]            xl_wdata,
    output logic                   xl_vld,
    output logic                   xl_err,
    output logic [PFN_W+OFF_W-1:0] xl_paddr,
    output logic                   xl_aux,
    output logic                   xl_swap,
    output logic                   xl_mem_we,
    output logic [1:0]             xl_mem_be,
    output logic [15:0]            xl_mem_wdata,
    input  logic [15:0]            mem_rdata,
    output logic [15:0]            xl_rdata
);
    localparam int unsigned USED_W = IDX_W + OFF_W;

    logic [IDX_W-1:0] lk_idx;
    logic [OFF_W-1:0] lk_off;
    logic [PFN_W-1:0] lk_pfn;
    logic             lk_swap;
    logic             lk_aux;
    logic             half_q;
    logic             lane_q;
    logic             unused_hi;

    // Purpose: split the address; the bits above USED_W are ignored.
    always_comb begin
        lk_idx    = xl_addr[USED_W-1:OFF_W];
        lk_off    = xl_addr[OFF_W-1:0];
        unused_hi = ^xl_addr[ADDR_W-1:USED_W];
    end

    pxm_map_store #(.IDX_W(IDX_W), .PFN_W(PFN_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (map_wr_en),
        .rd_en   (map_rd_en),
        .idx     (map_idx),
        .wdata   (map_wdata),
        .rdata   (map_rdata),
        .lk_idx  (lk_idx),
        .lk_pfn  (lk_pfn),
        .lk_swap (lk_swap),
        .lk_aux  (lk_aux)
    );

    pxm_xlate_stage #(.OFF_W(OFF_W), .PFN_W(PFN_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (xl_req),
        .off       (lk_off),
        .size      (pxm_pkg::xl_size_e'(xl_size)),
        .we        (xl_we),
        .wdata     (xl_wdata),
        .pfn       (lk_pfn),
        .swap      (lk_swap),
        .aux       (lk_aux),
        .vld       (xl_vld),
        .err       (xl_err),
        .paddr     (xl_paddr),
        .aux_q     (xl_aux),
        .swap_q    (xl_swap),
        .half_q    (half_q),
        .lane_q    (lane_q),
        .mem_we    (xl_mem_we),
        .mem_be    (xl_mem_be),
        .mem_wdata (xl_mem_wdata)
    );

    pxm_rd_return u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .vld   (xl_vld),
        .half  (half_q),
        .swap  (xl_swap),
        .lane  (lane_q),
        .raw   (mem_rdata),
        .rdata (xl_rdata)
    );
endmodule

// File: tb/sim_pagemap_xlate.sv
// Bench: directed scenarios for the paged address translation map.
module sim_pagemap_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_wr_en = 1'b0, map_rd_en = 1'b0;
    logic [9:0]  map_idx = '0;
    logic [15:0] map_wdata = '0, map_rdata;
    logic        xl_req = 1'b0, xl_we = 1'b0;
    logic [23:0] xl_addr = '0;
    logic [1:0]  xl_size = '0;
    logic [15:0] xl_wdata = '0, mem_rdata = '0;
    logic        xl_vld, xl_err, xl_aux, xl_swap, xl_mem_we;
    logic [21:0] xl_paddr;
    logic [1:0]  xl_mem_be;
    logic [15:0] xl_mem_wdata, xl_rdata;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    pagemap_xlate u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic map_wr(input logic [9:0] i, input logic [15:0] v);
        @(negedge clk);
        map_wr_en = 1'b1; map_idx = i; map_wdata = v;
        @(posedge clk); #1;
        map_wr_en = 1'b0;
    endtask

    task automatic map_rd(input logic [9:0] i);
        @(negedge clk);
        map_rd_en = 1'b1; map_idx = i;
        @(posedge clk); #1;
        map_rd_en = 1'b0;
    endtask

    task automatic xl(input logic [23:0] a, input logic [1:0] sz, input logic w,
                      input logic [15:0] wd, input logic [15:0] rd);
        @(negedge clk);
        xl_req = 1'b1; xl_addr = a; xl_size = sz; xl_we = w; xl_wdata = wd; mem_rdata = rd;
        @(posedge clk); #1;
        xl_req = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 vld after reset", xl_vld, 0);
        chk("R1 err after reset", xl_err, 0);
        map_rd(10'd5);    chk("R1 entry 5 zero", map_rdata, 16'h0000);
        map_rd(10'd1023); chk("R1 entry 1023 zero", map_rdata, 16'h0000);
    endtask

    task automatic t_basic;
        map_wr(10'd3, 16'h0ABC);
        xl(24'h000C55, 2'b01, 1'b0, 16'h0, 16'h0);
        chk("R3 vld", xl_vld, 1);
        chk("R3 R7 paddr", xl_paddr, {12'hABC, 10'h054});
        chk("R7 be", xl_mem_be, 2'b11);
        xl(24'hF00C54, 2'b01, 1'b1, 16'h1234, 16'hA1B2);
        chk("R2 upper bits ignored", xl_paddr, {12'hABC, 10'h054});
        chk("R3 mem_we", xl_mem_we, 1);
        chk("R5 no swap wdata", xl_mem_wdata, 16'h1234);
        chk("R5 no swap rdata", xl_rdata, 16'hA1B2);
        chk("R4 on-board", xl_aux, 0);
    endtask

    task automatic t_aux;
        map_wr(10'd4, 16'h2005);
        xl(24'h001000, 2'b01, 1'b0, 16'h0, 16'h0);
        chk("R4 aux route", xl_aux, 1);
        chk("R4 paddr", xl_paddr, {12'h005, 10'h000});
    endtask

    task automatic t_swap;
        map_wr(10'd6, 16'h8007);
        xl(24'h001802, 2'b01, 1'b1, 16'h1234, 16'hA1B2);
        chk("R5 swap flag", xl_swap, 1);
        chk("R5 swapped wdata", xl_mem_wdata, 16'h3412);
        chk("R5 swapped rdata", xl_rdata, 16'hB2A1);
    endtask

    task automatic t_byte;
        xl(24'h000C55, 2'b00, 1'b1, 16'h00CD, 16'hA1B2);
        chk("R6 be lane1", xl_mem_be, 2'b10);
        chk("R6 wdata lane1", xl_mem_wdata[15:8], 8'hCD);
        chk("R6 rdata lane1", xl_rdata, 16'h00A1);
        chk("R6 byte paddr odd", xl_paddr, {12'hABC, 10'h055});
        xl(24'h001801, 2'b00, 1'b1, 16'h00EF, 16'hA1B2);
        chk("R6 swapped lane0 be", xl_mem_be, 2'b01);
        chk("R6 swapped lane0 wdata", xl_mem_wdata[7:0], 8'hEF);
        chk("R6 swapped lane0 rdata", xl_rdata, 16'h00B2);
    endtask

    task automatic t_illegal;
        xl(24'h000C54, 2'b10, 1'b1, 16'h5555, 16'h0);
        chk("R8 err", xl_err, 1);
        chk("R8 no vld", xl_vld, 0);
        chk("R8 no be", xl_mem_be, 2'b00);
        chk("R8 no we", xl_mem_we, 0);
        xl(24'h000C54, 2'b11, 1'b0, 16'h0, 16'h0);
        chk("R8 err size3", xl_err, 1);
    endtask

    task automatic t_order;
        map_wr(10'd9, 16'h0011);
        @(negedge clk);
        map_wr_en = 1'b1; map_idx = 10'd9; map_wdata = 16'h0022;
        xl_req = 1'b1; xl_addr = 24'h002400; xl_size = 2'b01; xl_we = 1'b0;
        @(posedge clk); #1;
        map_wr_en = 1'b0; xl_req = 1'b0;
        chk("R9 same cycle old", xl_paddr, {12'h011, 10'h000});
        xl(24'h002400, 2'b01, 1'b0, 16'h0, 16'h0);
        chk("R9 next cycle new", xl_paddr, {12'h022, 10'h000});
    endtask

    task automatic t_readback;
        map_rd(10'd6);
        chk("R10 readback 6", map_rdata, 16'h8007);
        map_rd(10'd4);
        chk("R10 readback 4", map_rdata, 16'h2005);
    endtask

    task automatic t_top;
        map_wr(10'd1023, 16'h8000);
        xl(24'hFFFFF4, 2'b01, 1'b0, 16'h0, 16'h0);
        chk("R11 top alias paddr", xl_paddr, {12'h000, 10'h3F4});
        chk("R11 top swap", xl_swap, 1);
        xl(24'h0FFFF4, 2'b01, 1'b0, 16'h0, 16'h0);
        chk("R11 R2 top low nibble", xl_paddr, {12'h000, 10'h3F4});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset;
        t_basic;
        t_aux;
        t_swap;
        t_byte;
        t_illegal;
        t_order;
        t_readback;
        t_top;
        repeat (2) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #4000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule